// File: doc/BRIEF.md
# Modular Exponentiation Decryptor

This block raises a ciphertext value to a key exponent under a modulus and returns the result as a framed serial stream. A host presents the operand width code, the exponent, the modulus and the ciphertext on parallel inputs, then pulses `start`. The block samples all four values on that edge and raises `busy`. It reduces the ciphertext by the modulus and walks the exponent from its top bit down. Each step takes one modular squaring, plus one modular multiplication by the reduced ciphertext when the exponent bit is set. Every modular product is formed one multiplier bit per clock with a shift, an add and conditional subtractions.

The operand width is chosen per job as 2**n bits, where the maximum width `2**MAX_LOG` is fixed by a parameter. Input bits above the active width are ignored. When the result is ready it leaves on `msg`, most significant bit first, while `frame` is held high for exactly 2**n cycles. `busy` stays high until the last result bit has been sent and falls in the same cycle as `frame`.

Top module: `modexp_decryptor`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `busy`, `frame` and `msg` are low.
- R2: A `start` pulse seen while `busy` is low samples `n_log`, `key_d`, `modulus` and `cipher`, and `busy` is high from the next cycle onward.
- R3: The result equals cipher**key_d mod modulus, with all three operands taken as their low 2**n bits. Higher input bits have no effect. For example, with n=3, key 13, modulus 62 and cipher 27, the result is 29.
- R4: A cipher not smaller than the modulus gives the same result as its remainder. A zero exponent yields 1, or 0 when the modulus is 1.
- R5: The result is sent on `msg` most significant bit first, one bit per cycle, 2**n bits in all.
- R6: `frame` is high for exactly 2**n consecutive cycles per job, and `msg` is low whenever `frame` is low.
- R7: A `start` pulse while `busy` is high is ignored. The running job's result and frame length are unchanged.
- R8: `frame` is high only while `busy` is high, and `busy` falls in the same cycle that `frame` falls.
- R9: A width code above MAX_LOG is treated as MAX_LOG, and one below MIN_LOG is treated as MIN_LOG.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Single-cycle job request |
| n_log | input | NW | Width code n; active operand width is 2**n |
| key_d | input | 2**MAX_LOG | Exponent |
| modulus | input | 2**MAX_LOG | Modulus, nonzero within the active width |
| cipher | input | 2**MAX_LOG | Ciphertext base |
| busy | output | 1 | High from acceptance until the frame ends |
| msg | output | 1 | Serial result, MSB first |
| frame | output | 1 | High while `msg` carries result bits |

## Verification
The bench sweeps the 8-bit width over moduli that include 1, 2, powers of two and values next to the top of the range. These are combined with ciphertexts at and above the modulus and with exponents of zero, one and all ones. A design with a single subtraction per multiply step, or without the initial reduction, returns residues at or above the modulus. A design that mishandles the zero exponent or a modulus of 1 sends 1 where 0 is due, or the reverse. Operands with junk in the upper bits would expose a missing mask as a wrong result. Restart pulses in mid-job and mid-frame, and out-of-range width codes, catch a block that takes a new job while busy or that miscounts the frame. Such a block would show a changed result, a shorter frame, or `busy` falling apart from `frame`.

// File: rtl/mdx_pkg.sv
package mdx_pkg;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_REDUCE,
        CS_SQUARE,
        CS_MULT
    } ctrl_state_e;

    // one step of the serial product: which reductions fired
    typedef struct packed {
        logic sub_after_double;
        logic sub_after_add;
    } step_flags_t;

    function automatic int unsigned clamp_log(input int unsigned v,
                                              input int unsigned lo,
                                              input int unsigned hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/mdx_modmul.sv
module mdx_modmul
    import mdx_pkg::*;
#(
    parameter int LW = 4,
    parameter int W  = 1 << LW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [LW:0]   len,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic [W-1:0]  m,
    output logic          done,
    output logic [W-1:0]  r
);
    localparam int CW = LW + 1;

    logic [W-1:0]  a_q, m_q, bsh_q, r_q;
    logic [CW-1:0] cnt_q;
    logic          run_q, done_q;
    logic [CW-1:0] align;
    logic [W:0]    dbl, red1, sum, red2;
    step_flags_t   flags;

    assign align = CW'(W) - len;

    always_comb begin
        dbl  = {r_q, 1'b0};
        flags.sub_after_double = (dbl >= {1'b0, m_q});
        red1 = flags.sub_after_double ? (dbl - {1'b0, m_q}) : dbl;
        sum  = red1 + (bsh_q[W-1] ? {1'b0, a_q} : '0);
        flags.sub_after_add = (sum >= {1'b0, m_q});
        red2 = flags.sub_after_add ? (sum - {1'b0, m_q}) : sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q    <= '0;
            m_q    <= '0;
            bsh_q  <= '0;
            r_q    <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go) begin
                a_q   <= a;
                m_q   <= m;
                bsh_q <= b << align;
                r_q   <= '0;
                cnt_q <= len;
                run_q <= 1'b1;
            end else if (run_q) begin
                r_q   <= red2[W-1:0];
                bsh_q <= bsh_q << 1;
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign r    = r_q;

endmodule

// File: rtl/mdx_serout.sv
module mdx_serout #(
    parameter int LW = 4,
    parameter int W  = 1 << LW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [LW:0]   len,
    input  logic [W-1:0]  value,
    output logic          msg,
    output logic          frame,
    output logic          active
);
    localparam int CW = LW + 1;

    logic [W-1:0]  sh_q;
    logic [CW-1:0] cnt_q;
    logic          msg_q, frame_q;
    logic [CW-1:0] align;

    assign align = CW'(W) - len;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            cnt_q   <= '0;
            msg_q   <= 1'b0;
            frame_q <= 1'b0;
        end else if (load) begin
            sh_q    <= value << align;
            cnt_q   <= len;
            msg_q   <= 1'b0;
            frame_q <= 1'b0;
        end else if (cnt_q != '0) begin
            msg_q   <= sh_q[W-1];
            sh_q    <= sh_q << 1;
            cnt_q   <= cnt_q - CW'(1);
            frame_q <= 1'b1;
        end else begin
            msg_q   <= 1'b0;
            frame_q <= 1'b0;
        end
    end

    assign msg    = msg_q;
    assign frame  = frame_q;
    assign active = (cnt_q != '0) | frame_q;

endmodule

// File: rtl/mdx_ctrl.sv
module mdx_ctrl
    import mdx_pkg::*;
#(
    parameter int MIN_LOG = 3,
    parameter int MAX_LOG = 4,
    parameter int NW      = 3,
    parameter int LW      = MAX_LOG,
    parameter int W       = 1 << MAX_LOG
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [NW-1:0] n_in,
    input  logic [W-1:0]  d_in,
    input  logic [W-1:0]  m_in,
    input  logic [W-1:0]  s_in,
    input  logic          out_active,
    input  logic          mul_done,
    input  logic [W-1:0]  mul_r,
    output logic          mul_go,
    output logic [W-1:0]  mul_a,
    output logic [W-1:0]  mul_b,
    output logic [W-1:0]  mul_m,
    output logic [LW:0]   len,
    output logic          ser_load,
    output logic [W-1:0]  ser_val,
    output logic          busy
);
    localparam int CW = LW + 1;

    ctrl_state_e   state_q;
    logic [CW-1:0] len_q;
    logic [W-1:0]  d_q, m_q, one_q, sbar_q, a_q, b_q, val_q;
    logic [LW-1:0] idx_q;
    logic          go_q, load_q;

    logic [CW-1:0] len_c;
    logic [W-1:0]  mask_c, m_masked, one_c;
    logic          busy_c;

    always_comb begin
        len_c    = CW'(1) << clamp_log(int'(n_in), MIN_LOG, MAX_LOG);
        mask_c   = {W{1'b1}} >> (CW'(W) - len_c);
        m_masked = m_in & mask_c;
        one_c    = (m_masked == W'(1)) ? '0 : W'(1);
        busy_c   = (state_q != CS_IDLE) | load_q | out_active;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CS_IDLE;
            len_q   <= CW'(W);
            d_q     <= '0;
            m_q     <= '0;
            one_q   <= '0;
            sbar_q  <= '0;
            a_q     <= '0;
            b_q     <= '0;
            val_q   <= '0;
            idx_q   <= '0;
            go_q    <= 1'b0;
            load_q  <= 1'b0;
        end else begin
            go_q   <= 1'b0;
            load_q <= 1'b0;
            unique case (state_q)
                CS_IDLE: begin
                    if (start && !busy_c) begin
                        len_q   <= len_c;
                        d_q     <= d_in & mask_c;
                        m_q     <= m_masked;
                        one_q   <= one_c;
                        a_q     <= one_c;
                        b_q     <= s_in & mask_c;
                        idx_q   <= LW'(len_c - CW'(1));
                        go_q    <= 1'b1;
                        state_q <= CS_REDUCE;
                    end
                end
                CS_REDUCE: begin
                    if (mul_done) begin
                        sbar_q  <= mul_r;
                        a_q     <= one_q;
                        b_q     <= one_q;
                        go_q    <= 1'b1;
                        state_q <= CS_SQUARE;
                    end
                end
                CS_SQUARE: begin
                    if (mul_done) begin
                        if (d_q[idx_q]) begin
                            a_q     <= mul_r;
                            b_q     <= sbar_q;
                            go_q    <= 1'b1;
                            state_q <= CS_MULT;
                        end else if (idx_q == '0) begin
                            val_q   <= mul_r;
                            load_q  <= 1'b1;
                            state_q <= CS_IDLE;
                        end else begin
                            idx_q <= idx_q - LW'(1);
                            a_q   <= mul_r;
                            b_q   <= mul_r;
                            go_q  <= 1'b1;
                        end
                    end
                end
                CS_MULT: begin
                    if (mul_done) begin
                        if (idx_q == '0) begin
                            val_q   <= mul_r;
                            load_q  <= 1'b1;
                            state_q <= CS_IDLE;
                        end else begin
                            idx_q   <= idx_q - LW'(1);
                            a_q     <= mul_r;
                            b_q     <= mul_r;
                            go_q    <= 1'b1;
                            state_q <= CS_SQUARE;
                        end
                    end
                end
                default: state_q <= CS_IDLE;
            endcase
        end
    end

    assign mul_go   = go_q;
    assign mul_a    = a_q;
    assign mul_b    = b_q;
    assign mul_m    = m_q;
    assign len      = len_q;
    assign ser_load = load_q;
    assign ser_val  = val_q;
    assign busy     = busy_c;

endmodule

// File: rtl/modexp_decryptor.sv
module modexp_decryptor #(
    parameter int MIN_LOG = 3,
    parameter int MAX_LOG = 4,
    parameter int NW      = $clog2(MAX_LOG + 1),
    parameter int W       = 1 << MAX_LOG
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [NW-1:0] n_log,
    input  logic [W-1:0]  key_d,
    input  logic [W-1:0]  modulus,
    input  logic [W-1:0]  cipher,
    output logic          busy,
    output logic          msg,
    output logic          frame
);
    localparam int LW = MAX_LOG;

    logic          mul_go, mul_done, ser_load, out_active;
    logic [W-1:0]  mul_a, mul_b, mul_m, mul_r, ser_val;
    logic [LW:0]   len;

    mdx_ctrl #(
        .MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG), .NW(NW), .LW(LW), .W(W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .n_in(n_log),
        .d_in(key_d), .m_in(modulus), .s_in(cipher),
        .out_active(out_active), .mul_done(mul_done), .mul_r(mul_r),
        .mul_go(mul_go), .mul_a(mul_a), .mul_b(mul_b), .mul_m(mul_m),
        .len(len), .ser_load(ser_load), .ser_val(ser_val), .busy(busy)
    );

    mdx_modmul #(.LW(LW), .W(W)) u_mul (
        .clk(clk), .rst(rst), .go(mul_go), .len(len),
        .a(mul_a), .b(mul_b), .m(mul_m), .done(mul_done), .r(mul_r)
    );

    mdx_serout #(.LW(LW), .W(W)) u_out (
        .clk(clk), .rst(rst), .load(ser_load), .len(len), .value(ser_val),
        .msg(msg), .frame(frame), .active(out_active)
    );

endmodule

// File: rtl/mdx_checker.sv
module mdx_checker
    import mdx_pkg::*;
#(
    parameter int MIN_LOG = 3,
    parameter int MAX_LOG = 4,
    parameter int NW      = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [NW-1:0] n_log,
    input logic          busy,
    input logic          msg,
    input logic          frame
);
    localparam int CW = MAX_LOG + 2;

    logic [CW-1:0] exp_len_q, run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_len_q <= '0;
            run_q     <= '0;
        end else begin
            if (start && !busy)
                exp_len_q <= CW'(1) << clamp_log(int'(n_log), MIN_LOG, MAX_LOG);
            run_q <= frame ? run_q + CW'(1) : '0;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!busy && !frame && !msg)); // R1

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy); // R2

    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(frame) |-> (run_q == exp_len_q)); // R6

    AST_MSG_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !frame |-> !msg); // R6

    AST_FRAME_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        frame |-> busy); // R8

    AST_BUSY_WITH_FRAME: assert property (@(posedge clk) disable iff (rst)
        $fell(frame) |-> !busy); // R8

endmodule

bind modexp_decryptor mdx_checker #(
    .MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG), .NW(NW)
) u_mdx_checker (
    .clk(clk), .rst(rst), .start(start), .n_log(n_log),
    .busy(busy), .msg(msg), .frame(frame)
);

// File: tb/tb_modexp_decryptor.sv
`timescale 1ns/1ps
module tb_modexp_decryptor;
    localparam int MAX_LOG = 4;
    localparam int NW      = 3;
    localparam int W       = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [NW-1:0] n_log = '0;
    logic [W-1:0]  key_d = '0, modulus = '0, cipher = '0;
    logic          busy, msg, frame;

    int errors = 0;
    int checks = 0;
    bit done_all = 1'b0;

    always #10 clk = ~clk;

    modexp_decryptor #(.MIN_LOG(3), .MAX_LOG(MAX_LOG)) dut (
        .clk(clk), .rst(rst), .start(start), .n_log(n_log),
        .key_d(key_d), .modulus(modulus), .cipher(cipher),
        .busy(busy), .msg(msg), .frame(frame)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint unsigned model(input longint unsigned s,
                                              input longint unsigned d,
                                              input longint unsigned m,
                                              input int k);
        longint unsigned res = (m == 1) ? 0 : 1;
        longint unsigned base = s % m;
        for (int i = k - 1; i >= 0; i--) begin
            res = (res * res) % m;
            if (d[i]) res = (res * base) % m;
        end
        return res;
    endfunction

    // poke: 1 = restart pulse mid-compute, 2 = restart pulse mid-frame
    task automatic run_case(input int n, input logic [W-1:0] d,
                            input logic [W-1:0] m, input logic [W-1:0] s,
                            input int poke, input string req);
        int nc = (n < 3) ? 3 : ((n > MAX_LOG) ? MAX_LOG : n);
        int k = 1 << nc;
        longint unsigned mask = (64'd1 << k) - 1;
        longint unsigned exp_v = model(s & mask, d & mask, m & mask, k);
        longint unsigned got = 0;
        int wait_n = 0;
        bit ok_frame = 1'b1;
        @(negedge clk);
        n_log = NW'(n); key_d = d; modulus = m; cipher = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2", "busy after start", busy, 1);
        while (frame !== 1'b1 && wait_n < 20000) begin
            if (poke == 1 && wait_n == 5) begin
                n_log = NW'(MAX_LOG); key_d = '1; cipher = 16'h1234; start = 1'b1;
            end else start = 1'b0;
            @(negedge clk);
            wait_n++;
        end
        start = 1'b0;
        if (wait_n >= 20000) begin
            check(1'b0, req, "frame never rose", 0, 1);
            return;
        end
        for (int i = 0; i < k; i++) begin
            if (frame !== 1'b1) ok_frame = 1'b0;
            got = (got << 1) | longint'(msg);
            if (i == k - 1 && busy !== 1'b1) ok_frame = 1'b0;
            if (poke == 2 && i == 2) begin
                n_log = '0; key_d = 16'h00FF; start = 1'b1;
            end else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        check(got == exp_v, req, "result (R3/R5, MSB first)", got, exp_v);
        check(ok_frame, "R6", "frame high for full length", ok_frame, 1);
        check(frame == 1'b0 && busy == 1'b0 && msg == 1'b0, "R8",
              "frame, busy and msg low together after frame",
              {frame, busy, msg}, 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done_all) begin
            check(1'b0, "WDOG", "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] mods[12] = '{1, 2, 3, 5, 7, 62, 97, 128, 200, 251, 254, 255};
        logic [W-1:0] bases[6] = '{0, 1, 27, 61, 130, 255};
        logic [W-1:0] keys[6]  = '{0, 1, 2, 13, 128, 255};
        repeat (3) @(negedge clk);
        check(busy == 0 && frame == 0 && msg == 0, "R1", "outputs in reset",
              {busy, frame, msg}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 0 && frame == 0 && msg == 0, "R1", "outputs after reset",
              {busy, frame, msg}, 0);

        run_case(3, 16'd13, 16'd62, 16'd27, 0, "R3");
        // R3 upper input bits ignored
        run_case(3, 16'hA50D, 16'h3C3E, 16'h5A1B, 0, "R3");
        // R4 zero exponent, unit modulus, cipher at and above modulus
        run_case(3, 16'd0, 16'd97, 16'd200, 0, "R4");
        run_case(3, 16'd0, 16'd1, 16'd5, 0, "R4");
        run_case(3, 16'd7, 16'd62, 16'd62, 0, "R4");
        // sweep at the 8-bit width
        foreach (mods[i])
            foreach (bases[j])
                foreach (keys[q])
                    run_case(3, keys[q] | 16'hC300, mods[i], bases[j], 0, "R4");
        // full 16-bit width, R5 ordering across the widest frame
        run_case(4, 16'hFFFF, 16'hFFF1, 16'h8001, 0, "R5");
        run_case(4, 16'h0101, 16'h8000, 16'h0003, 0, "R5");
        run_case(4, 16'hABCD, 16'hE3D5, 16'h1F2E, 0, "R5");
        // R7 restart pulses while busy
        run_case(3, 16'd13, 16'd62, 16'd27, 1, "R7");
        run_case(3, 16'd13, 16'd62, 16'd27, 2, "R7");
        // R9 width code clamping
        run_case(7, 16'h1357, 16'hF00D, 16'h2468, 0, "R9");
        run_case(0, 16'h1357, 16'hF00D, 16'h2468, 0, "R9");
        run_case(1, 16'd13, 16'd62, 16'd27, 0, "R9");

        done_all = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule